// File: doc/BRIEF.md
# Stream Handshake Protocol Monitor

A passive observer for one valid/ready stream link that carries data, a valid flag, a ready flag and a packet-end marker. It taps the link without driving any of its wires. It counts every accepted beat and every accepted beat that closes a packet. It also checks the source side of the handshake contract: once a source offers a beat, it must keep that offer unchanged until the destination takes it.

A beat is accepted on a rising clock edge only when valid and ready are both high in that cycle. The destination may apply back-pressure freely. It may raise ready before valid, after valid, or not at all. Ready with no valid present is legal. The source may not withdraw or alter a stalled offer. A stalled offer is a cycle with valid high and ready low. After such a cycle, the next cycle must show valid still high, the same data and the same packet-end marker. Each of the three violation classes drives a combinational pulse in the cycle the bad value appears on the link. Each class also sets a sticky flag on the following edge, and only reset clears it.

Reset is synchronous and active low. Any offer seen during reset is forgotten. The first cycle after reset is therefore never compared against a stale copy.

Top module: `strm_hs_monitor`

## Requirements
- R1: `beat_count` increases by one after each clock edge where `mon_valid` and `mon_ready` are both high, and is unchanged after every other edge (including ready high with valid low).
- R2: `pkt_count` increases by one after each such accepting edge where `mon_last` is 1, and is unchanged otherwise.
- R3: Both counters stop at 2^CNT_W-1 and hold that value on further accepted beats.
- R4: If the previous edge saw valid=1 and ready=0, and valid is now 0, `err_drop_pulse` is 1 in this cycle.
- R5: If the previous edge saw valid=1 and ready=0, and valid is still 1 but `mon_data` differs from the value it had then, `err_data_pulse` is 1 in this cycle.
- R6: Same condition as R5 applied to `mon_last`, reported on `err_last_pulse`.
- R7: Legal traffic raises no pulse and sets no sticky flag. Legal traffic covers idle cycles, ready without valid, stalled offers held unchanged, and back-to-back accepted beats.
- R8: Each sticky flag becomes 1 on the edge that ends a cycle where its pulse is 1. It stays 1 until reset.
- R9: While `rst_n` is 0, counters and sticky flags are 0 after each edge. In the first cycle after reset, no pulse is raised, whatever the link showed during reset.
- R10: After a changed offer that is still stalled, the new value becomes the reference. Holding it for another cycle raises no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mon_data | input | DATA_W | Observed stream data |
| mon_valid | input | 1 | Observed source valid flag |
| mon_ready | input | 1 | Observed destination ready flag |
| mon_last | input | 1 | Observed packet-end marker |
| beat_count | output | CNT_W | Saturating count of accepted beats |
| pkt_count | output | CNT_W | Saturating count of accepted beats with marker set |
| err_drop_pulse | output | 1 | Offer withdrawn in this cycle |
| err_data_pulse | output | 1 | Offered data changed in this cycle |
| err_last_pulse | output | 1 | Offered marker changed in this cycle |
| err_drop_sticky | output | 1 | A withdrawal has been seen since reset |
| err_data_sticky | output | 1 | A data change has been seen since reset |
| err_last_sticky | output | 1 | A marker change has been seen since reset |

## Verification
The bench builds the block with DATA_W=8 and CNT_W=4. The narrow counter makes saturation reachable within a few dozen accepted beats, so R3 is checked on both counters. Eight data bits are enough to give every injected data change a distinct value. They also let the random legal traffic vary its payload from beat to beat while the source holds each stalled offer.

// File: rtl/strm_mon_pkg.sv
package strm_mon_pkg;

  typedef struct packed {
    logic drop;
    logic data;
    logic last;
  } hs_err_t;

  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned CNT_BEAT = 0;
  localparam int unsigned CNT_PKT  = 1;

endpackage

// File: rtl/hs_offer_track.sv
module hs_offer_track
  import strm_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic              last_i,
  output hs_err_t           err_o
);

  logic              pend_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;
  logic              stall;

  assign stall = valid_i & ~ready_i;

  // Hold a copy of each stalled offer; the copy follows the link while stalled
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else begin
      pend_q <= stall;
      if (stall) begin
        data_q <= data_i;
        last_q <= last_i;
      end
    end
  end

  always_comb begin
    err_o      = '0;
    err_o.drop = pend_q & ~valid_i;
    err_o.data = pend_q & valid_i & (data_i != data_q);
    err_o.last = pend_q & valid_i & (last_i != last_q);
  end

endmodule

// File: rtl/hs_sat_counter.sv
module hs_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hs_err_sticky.sv
module hs_err_sticky
  import strm_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  hs_err_t hit_i,
  output hs_err_t held_o
);

  hs_err_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
    end else begin
      held_q <= held_q | hit_i;
    end
  end

  assign held_o = held_q;

endmodule

// File: rtl/strm_hs_monitor.sv
module strm_hs_monitor
  import strm_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mon_data,
  input  logic              mon_valid,
  input  logic              mon_ready,
  input  logic              mon_last,
  output logic [CNT_W-1:0]  beat_count,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              err_drop_pulse,
  output logic              err_data_pulse,
  output logic              err_last_pulse,
  output logic              err_drop_sticky,
  output logic              err_data_sticky,
  output logic              err_last_sticky
);

  logic               fire;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  hs_err_t            err_now;
  hs_err_t            err_held;

  assign fire = mon_valid & mon_ready;
  assign cnt_inc[CNT_BEAT] = fire;
  assign cnt_inc[CNT_PKT]  = fire & mon_last;

  hs_offer_track #(.DATA_W(DATA_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_i  (mon_data),
    .valid_i (mon_valid),
    .ready_i (mon_ready),
    .last_i  (mon_last),
    .err_o   (err_now)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    hs_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_inc[gi]),
      .cnt_o (cnt_val[gi])
    );
  end

  hs_err_sticky u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (err_now),
    .held_o (err_held)
  );

  assign beat_count      = cnt_val[CNT_BEAT];
  assign pkt_count       = cnt_val[CNT_PKT];
  assign err_drop_pulse  = err_now.drop;
  assign err_data_pulse  = err_now.data;
  assign err_last_pulse  = err_now.last;
  assign err_drop_sticky = err_held.drop;
  assign err_data_sticky = err_held.data;
  assign err_last_sticky = err_held.last;

endmodule

// File: rtl/strm_hs_monitor_chk.sv
module strm_hs_monitor_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] mon_data,
  input logic              mon_valid,
  input logic              mon_ready,
  input logic              mon_last,
  input logic [CNT_W-1:0]  beat_count,
  input logic [CNT_W-1:0]  pkt_count,
  input logic              err_drop_pulse,
  input logic              err_data_pulse,
  input logic              err_last_pulse,
  input logic              err_drop_sticky,
  input logic              err_data_sticky,
  input logic              err_last_sticky
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic armed_q;
  always_ff @(posedge clk) armed_q <= rst_n;

  // R4
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(mon_valid && !mon_ready) && !mon_valid) |-> err_drop_pulse);

  // R5
  data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(mon_valid && !mon_ready) && mon_valid && (mon_data != $past(mon_data)))
      |-> err_data_pulse);

  // R6
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(mon_valid && !mon_ready) && mon_valid && (mon_last != $past(mon_last)))
      |-> err_last_pulse);

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_q && $past(mon_valid && !mon_ready))
      |-> !(err_drop_pulse || err_data_pulse || err_last_pulse));

  // R1
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && mon_ready && beat_count != CMAX)
      |=> beat_count == CNT_W'($past(beat_count) + 1'b1));

  // R1
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mon_valid && mon_ready) |=> $stable(beat_count));

  // R2
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mon_valid && mon_ready && mon_last) |=> $stable(pkt_count));

  // R3
  beat_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_count == CMAX) |=> (beat_count == CMAX));

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_drop_sticky || err_data_sticky || err_last_sticky)
      |=> ($countones({err_drop_sticky, err_data_sticky, err_last_sticky})
           >= $countones($past({err_drop_sticky, err_data_sticky, err_last_sticky}))));

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop_pulse |=> err_drop_sticky);

endmodule

bind strm_hs_monitor strm_hs_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .mon_data        (mon_data),
  .mon_valid       (mon_valid),
  .mon_ready       (mon_ready),
  .mon_last        (mon_last),
  .beat_count      (beat_count),
  .pkt_count       (pkt_count),
  .err_drop_pulse  (err_drop_pulse),
  .err_data_pulse  (err_data_pulse),
  .err_last_pulse  (err_last_pulse),
  .err_drop_sticky (err_drop_sticky),
  .err_data_sticky (err_data_sticky),
  .err_last_sticky (err_last_sticky)
);

// File: tb/strm_hs_monitor_tb.sv
`timescale 1ns/1ps
module strm_hs_monitor_tb_top;

  localparam int unsigned DW = 8;
  localparam int unsigned CW = 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] d = '0;
  logic          v = 1'b0, r = 1'b0, l = 1'b0;
  logic [CW-1:0] beats, pkts;
  logic          p_drop, p_data, p_last, s_drop, s_data, s_last;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  strm_hs_monitor #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_data(d), .mon_valid(v), .mon_ready(r),
    .mon_last(l), .beat_count(beats), .pkt_count(pkts),
    .err_drop_pulse(p_drop), .err_data_pulse(p_data), .err_last_pulse(p_last),
    .err_drop_sticky(s_drop), .err_data_sticky(s_data), .err_last_sticky(s_last)
  );

  // {valid, ready, last, data[7:0], exp drop/data/last pulse, exp beats[3:0], exp pkts[3:0]}
  localparam int NV = 11;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {3'b000, 8'h00, 3'b000, 4'd0, 4'd0},
    {3'b010, 8'h00, 3'b000, 4'd0, 4'd0},
    {3'b100, 8'hA1, 3'b000, 4'd0, 4'd0},
    {3'b100, 8'hA1, 3'b000, 4'd0, 4'd0},
    {3'b110, 8'hA1, 3'b000, 4'd0, 4'd0},
    {3'b111, 8'hB2, 3'b000, 4'd1, 4'd0},
    {3'b000, 8'h00, 3'b000, 4'd2, 4'd1},
    {3'b110, 8'hC3, 3'b000, 4'd2, 4'd1},
    {3'b101, 8'hD4, 3'b000, 4'd3, 4'd1},
    {3'b111, 8'hD4, 3'b000, 4'd3, 4'd1},
    {3'b010, 8'h00, 3'b000, 4'd4, 4'd2}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pulses(input string req, input logic [2:0] exp);
    chk({p_drop, p_data, p_last} == exp, req, int'({p_drop, p_data, p_last}), int'(exp));
  endtask

  task automatic chk_sticky(input string req, input logic [2:0] exp);
    chk({s_drop, s_data, s_last} == exp, req, int'({s_drop, s_data, s_last}), int'(exp));
  endtask

  // Drive at the falling edge, settle, then the caller samples before the next rising edge
  task automatic cyc(input logic vv, input logic rr, input logic ll, input logic [DW-1:0] dd);
    @(negedge clk);
    v = vv; r = rr; l = ll; d = dd;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v = 1'b0; r = 1'b0; l = 1'b0; d = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int mb, mp;
    logic hold;
    logic [DW-1:0] hd;
    logic hl;

    // R9: reset state
    repeat (2) @(negedge clk);
    #1;
    chk(beats == 0 && pkts == 0, "R9 counters in reset", int'(beats), 0);
    chk_sticky("R9 sticky in reset", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R7: table of legal traffic
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18:11]);
      chk_pulses("R7 table pulses", VEC[i][10:8]);
      chk(beats == VEC[i][7:4], "R1 table beats", int'(beats), int'(VEC[i][7:4]));
      chk(pkts == VEC[i][3:0], "R2 table packets", int'(pkts), int'(VEC[i][3:0]));
    end

    // R7: random back-pressure, source obeys the contract
    mb = 4; mp = 2; hold = 1'b0; hd = '0; hl = 1'b0;
    for (int i = 0; i < 60; i++) begin
      logic nv, nr;
      nr = 1'($urandom % 2);
      if (hold) nv = 1'b1;
      else begin
        nv = 1'($urandom % 2);
        hd = DW'($urandom);
        hl = 1'($urandom % 2);
      end
      cyc(nv, nr, hl, hd);
      chk_pulses("R7 random pulses", 3'b000);
      chk(beats == CW'(mb), "R1 R3 random beats", int'(beats), mb);
      chk(pkts == CW'(mp), "R2 R3 random packets", int'(pkts), mp);
      if (nv && nr) begin
        if (mb < int'(CMAX)) mb++;
        if (hl && mp < int'(CMAX)) mp++;
      end
      hold = nv && !nr;
    end
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk_sticky("R7 no sticky after legal traffic", 3'b000);

    // R3: saturation of both counters
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b1, 8'h5A);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk(beats == CMAX, "R3 beats saturate", int'(beats), int'(CMAX));
    chk(pkts == CMAX, "R3 packets saturate", int'(pkts), int'(CMAX));

    // R4: withdrawn offer
    do_reset();
    cyc(1'b1, 1'b0, 1'b0, 8'h11);
    chk_pulses("R4 stall itself is legal", 3'b000);
    cyc(1'b0, 1'b0, 1'b0, 8'h11);
    chk_pulses("R4 drop pulse", 3'b100);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk_pulses("R4 pulse lasts one cycle", 3'b000);
    chk_sticky("R8 drop sticky set", 3'b100);

    // R5 R10: data change, then held new value
    do_reset();
    cyc(1'b1, 1'b0, 1'b0, 8'h21);
    cyc(1'b1, 1'b0, 1'b0, 8'h22);
    chk_pulses("R5 data pulse", 3'b010);
    cyc(1'b1, 1'b0, 1'b0, 8'h22);
    chk_pulses("R10 new value is reference", 3'b000);
    cyc(1'b1, 1'b1, 1'b0, 8'h22);
    chk_pulses("R10 accepted beat quiet", 3'b000);
    chk_sticky("R8 data sticky set", 3'b010);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk(beats == 1, "R1 beat after data error", int'(beats), 1);

    // R6: marker change, with valid and data kept
    do_reset();
    cyc(1'b1, 1'b0, 1'b0, 8'h31);
    cyc(1'b1, 1'b0, 1'b1, 8'h31);
    chk_pulses("R6 last pulse", 3'b001);
    cyc(1'b1, 1'b1, 1'b1, 8'h31);
    chk_sticky("R8 last sticky set", 3'b001);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk(pkts == 1, "R2 packet after last error", int'(pkts), 1);

    // R8: stickies survive idle cycles; add the other two classes
    cyc(1'b1, 1'b0, 1'b0, 8'h40);
    cyc(1'b0, 1'b0, 1'b0, 8'h40);
    cyc(1'b1, 1'b0, 1'b0, 8'h41);
    cyc(1'b1, 1'b0, 1'b0, 8'h42);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk_sticky("R8 all stickies held", 3'b111);
    chk_pulses("R8 no pulse while idle", 3'b000);

    // R9: offer during reset is not compared after release
    @(negedge clk);
    rst_n = 1'b0; v = 1'b1; r = 1'b0; l = 1'b1; d = 8'h55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; v = 1'b1; r = 1'b0; l = 1'b0; d = 8'h66;
    #1;
    chk_pulses("R9 first cycle after reset quiet", 3'b000);
    chk_sticky("R9 stickies cleared", 3'b000);
    chk(beats == 0 && pkts == 0, "R9 counters cleared", int'(beats), 0);
    cyc(1'b0, 1'b0, 1'b0, 8'h66);
    chk_pulses("R4 drop right after reset", 3'b100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule